// File: doc/BRIEF.md
# Complementary Output Deadtime Generator

This block turns one PWM reference per channel into a pair of outputs, a main output and its complement, for driving the high and low switches of a half bridge. When a channel runs in pair mode, the complement is the inverse of the reference. Each output may only turn active once the reference has held the level that activates it for a programmed number of clock cycles. The two switches therefore never conduct together. A reference pulse that is no longer than that interval produces no output pulse at all.

Per-channel enable bits also steer the reference. With only one enable set, that output carries the reference directly with no deadtime, and the other output stays inactive. In this case the complement is not inverted. Each output has its own polarity bit, and a master enable forces every output to its inactive level. The deadtime value is 8 bits wide and is shared by all channels. The path from the reference to the outputs has a latency of two clock cycles. The control inputs take effect one cycle after they are sampled.

Top module: `cdt_pair_gen`

## Requirements
- R1: While rst_n is low at a clock edge, both outputs of every channel read 0 after that edge, whatever the reference and polarity inputs are.
- R2: In pair mode (both enables and out_en set, main polarity 0), main_out is high two cycles after a sample k exactly when the reference was high in samples k-D through k. D is the deadtime value sampled at the most recent reference edge, so the rising edge lags by D cycles and the falling edge is not delayed.
- R3: In pair mode with complement polarity 0, comp_out is high two cycles after sample k exactly when the reference was low in samples k-D through k. So comp_out is the inverted reference with its rising edge delayed by D cycles.
- R4: In pair mode, a high or low reference pulse lasting D samples or fewer produces no pulse on the output it would activate. A pulse of D+1 samples produces a one-cycle pulse.
- R5: A deadtime value of 0 gives no delay: in pair mode, main_out equals the reference and comp_out its inverse, two cycles later.
- R6: With the main enable set, the complement enable clear and out_en set, main_out carries the reference two cycles later with no deadtime, and comp_out stays at its inactive level.
- R7: With only the complement enable set and out_en set, comp_out carries the reference two cycles later, not inverted and with no deadtime, and main_out stays at its inactive level.
- R8: A polarity bit of 0 makes its output active high. A 1 inverts that output, so its inactive level becomes 1. Polarity takes effect one cycle after it is sampled.
- R9: When out_en is 0, both outputs of every channel sit at their inactive levels (equal to their polarity bits) one cycle later.
- R10: A channel with neither enable set holds both outputs at their inactive levels. Each channel's mode is independent of the others.
- R11: The deadtime value is captured at each reference edge. Changing it while a hold is in progress does not change the length of that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | NUM_CH | PWM reference, one bit per channel |
| main_en | input | NUM_CH | Main output enable per channel |
| comp_en | input | NUM_CH | Complement output enable per channel |
| main_pol | input | NUM_CH | Main output polarity (1 = inverted) |
| comp_pol | input | NUM_CH | Complement output polarity (1 = inverted) |
| out_en | input | 1 | Master output enable for all channels |
| dead_cyc | input | DT_W | Deadtime in clock cycles, shared by all channels |
| main_out | output | NUM_CH | Main outputs |
| comp_out | output | NUM_CH | Complement outputs |

## Verification
The hardest case to reach is the exact boundary of pulse suppression. It needs pulses of D and D+1 samples in both directions, and a deadtime change made in the middle of a hold. Plain PWM traffic never lines up with these. The stimulus therefore drives hand-shaped pulse trains of 2, 5 and 6 samples against a deadtime of 5, and rewrites the deadtime while the reference is held. A scoreboard model tracks, per channel, how long the reference has held its level and which deadtime was captured at the last edge.

// File: rtl/cdt_pkg.sv
// Shared types for the complementary output deadtime generator.
// Assumes: steering is decided per channel from the master enable and
// the two channel enables.
package cdt_pkg;

    typedef enum logic [1:0] {
        STEER_OFF  = 2'd0,
        STEER_COMP = 2'd1,
        STEER_MAIN = 2'd2,
        STEER_PAIR = 2'd3
    } steer_t;

    // Map the enables to a steering mode; master low wins over everything.
    function automatic steer_t steer_decode(input logic master,
                                            input logic m_en,
                                            input logic c_en);
        steer_t mode;
        if (!master) begin
            mode = STEER_OFF;
        end else begin
            case ({m_en, c_en})
                2'b11:   mode = STEER_PAIR;
                2'b10:   mode = STEER_MAIN;
                2'b01:   mode = STEER_COMP;
                default: mode = STEER_OFF;
            endcase
        end
        return mode;
    endfunction

endpackage

// File: rtl/cdt_dead_unit.sv
// Deadtime timer for one channel.
// Produces active-high main/complement levels one cycle after the
// reference sample. An output level is granted only once the reference
// has held that level for dead_cyc further samples. A down-counter is
// loaded at every reference edge with the deadtime sampled at that edge.
// Assumes: the reference is synchronous to clk.
module cdt_dead_unit #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_in,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            ref_q,
    output logic            main_raw,
    output logic            comp_raw
);

    logic [DT_W-1:0] cnt_q;
    logic [DT_W-1:0] cnt_nxt;
    logic            edge_seen;
    logic            settled;

    // Reload on a reference edge, otherwise count down and stop at zero.
    always_comb begin
        edge_seen = ref_in ^ ref_q;
        if (edge_seen) begin
            cnt_nxt = dead_cyc;
        end else if (cnt_q != '0) begin
            cnt_nxt = cnt_q - 1'b1;
        end else begin
            cnt_nxt = cnt_q;
        end
        settled = (cnt_nxt == '0);
    end

    // Register the reference history, the timer and the granted levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q    <= 1'b0;
            cnt_q    <= '0;
            main_raw <= 1'b0;
            comp_raw <= 1'b0;
        end else begin
            ref_q    <= ref_in;
            cnt_q    <= cnt_nxt;
            main_raw <= ref_in & settled;
            comp_raw <= ~ref_in & settled;
        end
    end

    // R2: with a nonzero deadtime, main may not rise on the sample of a fresh rising edge
    a_r2_main_waits: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(main_raw) && $past(dead_cyc) != '0) |-> $past(ref_q));

    // R3: with a nonzero deadtime, the complement may not rise on the sample of a fresh falling edge
    a_r3_comp_waits: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(comp_raw) && $past(dead_cyc) != '0) |-> !$past(ref_q));

endmodule

// File: rtl/cdt_steer.sv
// Output steering and polarity for one channel.
// Selects per mode between the deadtime levels, the directly passed
// reference, or inactive, then applies the registered polarity bits.
// Assumes: its inputs come from cdt_dead_unit, one cycle after the sample.
module cdt_steer
    import cdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  steer_t mode,
    input  logic   main_pol,
    input  logic   comp_pol,
    input  logic   ref_q,
    input  logic   main_raw,
    input  logic   comp_raw,
    output logic   main_out,
    output logic   comp_out
);

    logic act_m_q, act_c_q;
    logic act_m_d, act_c_d;
    logic pol_m_q, pol_c_q;

    // Choose the active-high level of each output for the current mode.
    always_comb begin
        act_m_d = 1'b0;
        act_c_d = 1'b0;
        case (mode)
            STEER_PAIR: begin
                act_m_d = main_raw;
                act_c_d = comp_raw;
            end
            STEER_MAIN: act_m_d = ref_q;
            STEER_COMP: act_c_d = ref_q;
            default: begin
                act_m_d = 1'b0;
                act_c_d = 1'b0;
            end
        endcase
    end

    // Register the active levels and the polarity that goes with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_m_q <= 1'b0;
            act_c_q <= 1'b0;
            pol_m_q <= 1'b0;
            pol_c_q <= 1'b0;
        end else begin
            act_m_q <= act_m_d;
            act_c_q <= act_c_d;
            pol_m_q <= main_pol;
            pol_c_q <= comp_pol;
        end
    end

    // Apply polarity: a set bit inverts the output.
    always_comb begin
        main_out = act_m_q ^ pol_m_q;
        comp_out = act_c_q ^ pol_c_q;
    end

    // R3: the two active levels are never asserted together
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_m_q && act_c_q));

    // R9: an off mode leaves both outputs inactive
    a_r9_off_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == STEER_OFF) |-> (!act_m_q && !act_c_q));

    // R6: in main-only mode the complement stays inactive
    a_r6_comp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == STEER_MAIN) |-> !act_c_q);

    // R7: in complement-only mode the main output stays inactive
    a_r7_main_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == STEER_COMP) |-> !act_m_q);

endmodule

// File: rtl/cdt_pair_gen.sv
// Complementary output deadtime generator, NUM_CH channels.
// Every channel has its own deadtime timer and steering stage. The
// deadtime value and the master enable are shared by all channels.
// Assumes: all inputs are synchronous to clk.
module cdt_pair_gen
    import cdt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ref_in,
    input  logic [NUM_CH-1:0] main_en,
    input  logic [NUM_CH-1:0] comp_en,
    input  logic [NUM_CH-1:0] main_pol,
    input  logic [NUM_CH-1:0] comp_pol,
    input  logic              out_en,
    input  logic [DT_W-1:0]   dead_cyc,
    output logic [NUM_CH-1:0] main_out,
    output logic [NUM_CH-1:0] comp_out
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        steer_t mode;
        logic   ref_q, main_raw, comp_raw;

        // Decode this channel's steering mode.
        always_comb mode = steer_decode(out_en, main_en[ch], comp_en[ch]);

        cdt_dead_unit #(.DT_W(DT_W)) u_dead (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_in   (ref_in[ch]),
            .dead_cyc (dead_cyc),
            .ref_q    (ref_q),
            .main_raw (main_raw),
            .comp_raw (comp_raw)
        );

        cdt_steer u_steer (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .main_pol (main_pol[ch]),
            .comp_pol (comp_pol[ch]),
            .ref_q    (ref_q),
            .main_raw (main_raw),
            .comp_raw (comp_raw),
            .main_out (main_out[ch]),
            .comp_out (comp_out[ch])
        );
    end

endmodule

// File: tb/cdt_pair_gen_test.sv
module cdt_pair_gen_test;

    localparam int NCH = 4;
    localparam int DW  = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n;
    logic [NCH-1:0] ref_in, m_en, c_en, m_pol, c_pol;
    logic           master;
    logic [DW-1:0]  dead;
    logic [NCH-1:0] main_out, comp_out;

    cdt_pair_gen #(.NUM_CH(NCH), .DT_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .main_en(m_en), .comp_en(c_en), .main_pol(m_pol), .comp_pol(c_pol),
        .out_en(master), .dead_cyc(dead),
        .main_out(main_out), .comp_out(comp_out)
    );

    typedef struct {
        int             tgt;
        logic [NCH-1:0] em;
        logic [NCH-1:0] ec;
        string          tag;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    string tag_now = "R1";

    // pending configuration, applied at the next driven sample
    logic [NCH-1:0] p_men, p_cen, p_mpol, p_cpol;
    logic           p_master;
    logic [DW-1:0]  p_dead;

    // reference model state: stage-one values and per-channel hold tracking
    logic [NCH-1:0] h_ref, s_ref, s_rm, s_rc;
    int             h_len [NCH];
    int             h_dl  [NCH];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare outputs just after each edge against queued items
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].tgt == cyc) begin
                item_t it;
                it = sbq.pop_front();
                checks++;
                if (main_out !== it.em || comp_out !== it.ec) begin
                    failures++;
                    $display("FAIL %s cycle=%0d main actual=%b expected=%b comp actual=%b expected=%b",
                             it.tag, cyc, main_out, it.em, comp_out, it.ec);
                end
            end
        end
    end

    // driver: one reference sample, plus the expectation for the edge that follows
    task automatic drive(input logic [NCH-1:0] r);
        item_t it;
        @(negedge clk);
        rst_n  = 1'b1;
        ref_in = r;
        m_en   = p_men;
        c_en   = p_cen;
        m_pol  = p_mpol;
        c_pol  = p_cpol;
        master = p_master;
        dead   = p_dead;
        it.tgt = cyc + 1;
        it.tag = tag_now;
        for (int ch = 0; ch < NCH; ch++) begin
            logic am, ac;
            am = 1'b0;
            ac = 1'b0;
            if (p_master) begin
                if (p_men[ch] && p_cen[ch]) begin
                    am = s_rm[ch];
                    ac = s_rc[ch];
                end else if (p_men[ch]) begin
                    am = s_ref[ch];
                end else if (p_cen[ch]) begin
                    ac = s_ref[ch];
                end
            end
            it.em[ch] = am ^ p_mpol[ch];
            it.ec[ch] = ac ^ p_cpol[ch];
        end
        sbq.push_back(it);
        for (int ch = 0; ch < NCH; ch++) begin
            logic held;
            if (r[ch] != h_ref[ch]) begin
                h_len[ch] = 1;
                h_dl[ch]  = int'(p_dead);
            end else if (h_len[ch] < 100000) begin
                h_len[ch]++;
            end
            held      = h_len[ch] > h_dl[ch];
            s_rm[ch]  = r[ch] & held;
            s_rc[ch]  = ~r[ch] & held;
            s_ref[ch] = r[ch];
            h_ref[ch] = r[ch];
        end
    endtask

    task automatic drive_all(input logic v, input int n);
        for (int i = 0; i < n; i++) drive(v ? '1 : '0);
    endtask

    task automatic cfg_pair(input logic [DW-1:0] d);
        p_men = '1; p_cen = '1; p_mpol = '0; p_cpol = '0; p_master = 1'b1; p_dead = d;
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        #(4 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset holds outputs at 0 regardless of reference and polarity
        rst_n = 1'b0; ref_in = '1; m_en = '1; c_en = '1; m_pol = '1; c_pol = '1;
        master = 1'b1; dead = 8'd0;
        h_ref = '0; s_ref = '0; s_rm = '0; s_rc = '0;
        for (int ch = 0; ch < NCH; ch++) begin h_len[ch] = 1000; h_dl[ch] = 0; end
        repeat (3) @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            @(posedge clk);
            #1;
            checks++;
            if (main_out !== '0 || comp_out !== '0) begin
                failures++;
                $display("FAIL R1 main actual=%b expected=0000 comp actual=%b expected=0000",
                         main_out, comp_out);
            end
            ref_in = ~ref_in;
        end

        // R5: zero deadtime, Gray-code style reference per channel
        tag_now = "R5 zero deadtime";
        cfg_pair(8'd0);
        for (int i = 0; i < 24; i++) drive(NCH'(i ^ (i >> 1)));

        // R2 R3: deadtime 3, channels with different periods
        tag_now = "R2 R3 pair deadtime";
        cfg_pair(8'd3);
        for (int i = 0; i < 72; i++) begin
            logic [NCH-1:0] r;
            for (int ch = 0; ch < NCH; ch++) r[ch] = ((i / (ch + 3)) % 2) == 1;
            drive(r);
        end

        // R4: pulses at and around the deadtime of 5, both polarities of pulse
        tag_now = "R4 short pulse suppression";
        cfg_pair(8'd5);
        drive_all(0, 8); drive_all(1, 2); drive_all(0, 8); drive_all(1, 5);
        drive_all(0, 8); drive_all(1, 6); drive_all(0, 8);
        drive_all(1, 10); drive_all(0, 3); drive_all(1, 10); drive_all(0, 5);
        drive_all(1, 10); drive_all(0, 6); drive_all(1, 10);

        // R11: deadtime rewritten while a hold is counting
        tag_now = "R11 deadtime captured at edge";
        cfg_pair(8'd6);
        drive_all(0, 2);
        p_dead = 8'd1;
        drive_all(0, 9);
        p_dead = 8'd7;
        drive_all(1, 1);
        p_dead = 8'd2;
        drive_all(1, 10);

        // R6: main-only bypass ignores the deadtime
        tag_now = "R6 main-only bypass";
        cfg_pair(8'd4); p_cen = '0;
        for (int i = 0; i < 20; i++) drive(NCH'((i * 5) ^ (i >> 2)));

        // R7: complement-only bypass, not inverted
        tag_now = "R7 comp-only bypass";
        cfg_pair(8'd4); p_men = '0;
        for (int i = 0; i < 20; i++) drive(NCH'((i * 3) ^ (i >> 1)));

        // R8: polarity bits invert outputs in pair mode
        tag_now = "R8 polarity";
        cfg_pair(8'd2); p_mpol = 4'b0101; p_cpol = 4'b0011;
        for (int i = 0; i < 30; i++) drive(NCH'(((i / 4) % 2) != 0 ? 4'b1010 : 4'b0110));

        // R10: each channel in its own mode, one with neither enable
        tag_now = "R10 mixed modes";
        cfg_pair(8'd1); p_men = 4'b0011; p_cen = 4'b0101; p_mpol = 4'b1001; p_cpol = 4'b1100;
        for (int i = 0; i < 24; i++) drive(NCH'(i ^ (i >> 2)));

        // R9: master enable low forces inactive levels, then recovers
        tag_now = "R9 master off";
        cfg_pair(8'd2); p_mpol = 4'b0110; p_cpol = 4'b1010; p_master = 1'b0;
        for (int i = 0; i < 16; i++) drive(NCH'(i));
        p_master = 1'b1;
        for (int i = 0; i < 12; i++) drive(NCH'(i * 7));

        tag_now = "R2 R3 drain";
        drive_all(0, 4);
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (sbq.size() != 0) begin
            failures++;
            $display("FAIL R2 scoreboard actual=%0d pending expected=0", sbq.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule